// File: doc/BRIEF.md
# Prioritized Interrupt Request and Service Controller

This block keeps track of interrupt vectors for one processor. It holds three 256-bit vectors: one marks vectors waiting for service, one marks vectors being serviced, and one records whether each vector last arrived as level-triggered or edge-triggered. The vector number is also its priority. The upper four bits of a vector form its priority class.

Software sets a task priority. The block combines it with the highest in-service vector to form a processor priority. The block raises an interrupt line when a waiting request belongs to a class above that priority. On an acknowledge strobe it moves the winning request into service and reports its vector. If the acknowledge should not be honoured, it reports a programmable spurious vector instead. An end-of-interrupt strobe retires the highest in-service vector. An event counter counts only arrivals that were not already waiting, so software can spot requests that merged with one already pending.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_out, ppr_out, event_count and ack_valid are 0. The spurious register resets to 0x0FF, which leaves the controller disabled, so a request that arrives before software enables it does not raise irq_out.
- R2: An arriving vector (req_valid with req_vector) marks that vector as pending. An honoured acknowledge always picks the highest-numbered pending vector.
- R3: ack_level returns the trigger mode of the acknowledged vector as set by its most recent arrival (req_level 1 means level, 0 means edge). A later arrival of the same vector overwrites the mode. ack_level is 0 when the spurious vector is returned.
- R4: ppr_out equals the task priority when task priority bits [7:4] are greater than or equal to the in-service class. The in-service class is bits [7:4] of the highest in-service vector, or 0 when nothing is in service. Otherwise ppr_out equals that class followed by four zero bits.
- R5: irq_out is 1 only when all of these hold: spurious register bit 8 is set, some vector is pending, and either ppr_out is 0 or the highest pending vector's bits [7:4] are strictly greater than ppr_out bits [7:4].
- R6: An acknowledge returns spurious register bits [7:0] and changes no vector state in any of these cases: the controller is disabled, nothing is pending, or the task priority is nonzero and the highest pending vector is less than or equal to it.
- R7: Any other acknowledge clears the winning pending bit and sets the same bit in service. ack_vector, ack_level and a one-cycle ack_valid appear at the clock edge that samples the strobe.
- R8: End-of-interrupt clears only the highest set in-service bit. With nothing in service it changes nothing.
- R9: event_count increments by one for each arrival whose pending bit was clear before the edge. A repeat of a pending vector leaves it unchanged.
- R10: A task-priority write takes wr_data[7:0]. A spurious-register write takes wr_data[8:0]. Higher write bits are ignored.
- R11: Acknowledge and end-of-interrupt act on the state before the edge. An arrival in the same cycle is applied after the acknowledge's clear, so a vector acknowledged and re-requested together stays pending and is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An interrupt vector arrives this cycle |
| req_vector | input | 8 | Arriving vector number |
| req_level | input | 1 | Trigger mode of the arrival: 1 level, 0 edge |
| wr_data | input | 32 | Register write data |
| tpr_wr | input | 1 | Write the task priority from wr_data |
| spur_wr | input | 1 | Write the spurious register from wr_data |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the processor |
| ack_valid | output | 1 | One-cycle pulse: ack_vector and ack_level are fresh |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| ack_level | output | 1 | Trigger mode of the returned vector |
| ppr_out | output | 8 | Current processor priority |
| event_count | output | 16 | Count of arrivals that were not already pending |

## Verification
The hardest situation to reach from the ports is one where the processor priority comes from the in-service class instead of the task priority, while a request of the same class waits and must stay blocked. The stimulus builds this by acknowledging a vector while the task priority sits one class lower, then sending a request of that same class, then retiring the in-service vector to release it. A second hard case is an acknowledge and a request for the same vector in one cycle. It is driven directly, and the surviving pending bit is exposed afterwards through a retire and a second acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   // outcome of an acknowledge strobe
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,
      ACK_SPUR  = 2'd1,
      ACK_TAKE  = 2'd2
   } ack_kind_e;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/irq_msb_find.sv
// Highest set bit of a small vector; found is low when no bit is set.
module irq_msb_find #(
   parameter int W  = 32,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  bits,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < W; i++) begin
         if (bits[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vec_encode.sv
// Two-level highest-set-bit encoder: per-group finders, then a group select.
module irq_vec_encode #(
   parameter int N   = 256,
   parameter int GRP = 32,
   localparam int NGRP = N / GRP,
   localparam int GW   = $clog2(GRP),
   localparam int SW   = $clog2(NGRP),
   localparam int IW   = $clog2(N)
) (
   input  logic [N-1:0]  bits,
   output logic          any,
   output logic [IW-1:0] top
);
   logic [NGRP-1:0] grp_found;
   logic [GW-1:0]   grp_idx [NGRP];
   logic [SW-1:0]   grp_sel;

   if (!irq_ctrl_pkg::is_pow2(GRP) || GRP < 2 || NGRP < 2) begin : g_bad_cfg
      $error("irq_vec_encode: GRP must be a power of two, at least 2, and below N");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      irq_msb_find #(.W(GRP)) u_find (
         .bits  (bits[g*GRP +: GRP]),
         .found (grp_found[g]),
         .idx   (grp_idx[g])
      );
   end

   irq_msb_find #(.W(NGRP)) u_sel (
      .bits  (grp_found),
      .found (any),
      .idx   (grp_sel)
   );

   assign top = {grp_sel, grp_idx[grp_sel]};
endmodule

// File: rtl/irq_ppr_calc.sv
// Processor priority from task priority and highest in-service vector.
module irq_ppr_calc #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4,
   localparam int SUB_W = VEC_W - CLS_W
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_any,
   input  logic [VEC_W-1:0] isr_top,
   output logic [VEC_W-1:0] ppr
);
   logic [CLS_W-1:0] isr_cls;
   logic [CLS_W-1:0] tpr_cls;

   assign isr_cls = isr_any ? isr_top[VEC_W-1 -: CLS_W] : '0;
   assign tpr_cls = tpr[VEC_W-1 -: CLS_W];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {SUB_W{1'b0}}};
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_VEC = 256,
   parameter int GRP_W   = 32,
   parameter int CLS_W   = 4,
   parameter int REG_W   = 32,
   parameter int CNT_W   = 16,
   localparam int VEC_W  = $clog2(NUM_VEC),
   localparam int SPR_W  = VEC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vector,
   input  logic             req_level,
   input  logic [REG_W-1:0] wr_data,
   input  logic             tpr_wr,
   input  logic             spur_wr,
   input  logic             ack,
   input  logic             eoi,
   output logic             irq_out,
   output logic             ack_valid,
   output logic [VEC_W-1:0] ack_vector,
   output logic             ack_level,
   output logic [VEC_W-1:0] ppr_out,
   output logic [CNT_W-1:0] event_count
);
   import irq_ctrl_pkg::*;

   localparam logic [SPR_W-1:0] SPR_RST = {1'b0, {VEC_W{1'b1}}};
   localparam logic [NUM_VEC-1:0] ONE_HOT0 = {{(NUM_VEC-1){1'b0}}, 1'b1};

   if (!is_pow2(NUM_VEC) || NUM_VEC < 16) begin : g_bad_num
      $error("irq_prio_ctrl: NUM_VEC must be a power of two, at least 16");
   end
   if (CLS_W < 1 || CLS_W >= VEC_W) begin : g_bad_cls
      $error("irq_prio_ctrl: CLS_W must be between 1 and VEC_W-1");
   end
   if (REG_W < SPR_W) begin : g_bad_reg
      $error("irq_prio_ctrl: REG_W too narrow for the spurious register");
   end

   // state
   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [VEC_W-1:0]   tpr_q;
   logic [SPR_W-1:0]   svr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [VEC_W-1:0]   ack_vec_q;
   logic               ack_lvl_q, ack_vld_q;

   // encoders
   logic             irr_any, isr_any;
   logic [VEC_W-1:0] irr_top, isr_top;
   logic [VEC_W-1:0] ppr;

   irq_vec_encode #(.N(NUM_VEC), .GRP(GRP_W)) u_irr_enc (
      .bits (irr_q), .any (irr_any), .top (irr_top)
   );
   irq_vec_encode #(.N(NUM_VEC), .GRP(GRP_W)) u_isr_enc (
      .bits (isr_q), .any (isr_any), .top (isr_top)
   );
   irq_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
      .tpr (tpr_q), .isr_any (isr_any), .isr_top (isr_top), .ppr (ppr)
   );

   // interrupt line
   logic             sw_en;
   logic [CLS_W-1:0] irr_cls, ppr_cls;
   assign sw_en   = svr_q[VEC_W];
   assign irr_cls = irr_top[VEC_W-1 -: CLS_W];
   assign ppr_cls = ppr[VEC_W-1 -: CLS_W];
   assign irq_out = sw_en && irr_any && ((ppr == '0) || (irr_cls > ppr_cls));

   // acknowledge decision
   ack_kind_e ack_kind;
   logic      tpr_blocks;
   assign tpr_blocks = (tpr_q != '0) && (irr_top <= tpr_q);

   always_comb begin
      if (!ack)                                 ack_kind = ACK_IDLE;
      else if (!sw_en || !irr_any || tpr_blocks) ack_kind = ACK_SPUR;
      else                                      ack_kind = ACK_TAKE;
   end

   // one-hot masks, all from pre-edge state
   logic [NUM_VEC-1:0] take_mask, eoi_mask, req_mask;
   assign take_mask = (ack_kind == ACK_TAKE)  ? (ONE_HOT0 << irr_top)    : '0;
   assign eoi_mask  = (eoi && isr_any)        ? (ONE_HOT0 << isr_top)    : '0;
   assign req_mask  = req_valid               ? (ONE_HOT0 << req_vector) : '0;

   logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
   assign irr_d = (irr_q & ~take_mask) | req_mask;
   assign isr_d = (isr_q | take_mask) & ~eoi_mask;
   assign tmr_d = req_level ? (tmr_q | req_mask) : (tmr_q & ~req_mask);

   logic new_arrival;
   assign new_arrival = req_valid && !irr_q[req_vector];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
      end else begin
         irr_q <= irr_d;
         isr_q <= isr_d;
         tmr_q <= tmr_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q <= '0;
         svr_q <= SPR_RST;
      end else begin
         if (tpr_wr)  tpr_q <= wr_data[VEC_W-1:0];
         if (spur_wr) svr_q <= wr_data[SPR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (new_arrival) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vld_q <= 1'b0;
         ack_vec_q <= '0;
         ack_lvl_q <= 1'b0;
      end else begin
         ack_vld_q <= ack;
         if (ack_kind == ACK_TAKE) begin
            ack_vec_q <= irr_top;
            ack_lvl_q <= tmr_q[irr_top];
         end else if (ack_kind == ACK_SPUR) begin
            ack_vec_q <= svr_q[VEC_W-1:0];
            ack_lvl_q <= 1'b0;
         end
      end
   end

   assign ack_valid   = ack_vld_q;
   assign ack_vector  = ack_vec_q;
   assign ack_level   = ack_lvl_q;
   assign ppr_out     = ppr;
   assign event_count = cnt_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int NUM_VEC = 256,
   parameter int CLS_W   = 4,
   parameter int CNT_W   = 16,
   localparam int VEC_W  = $clog2(NUM_VEC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               ack,
   input logic               eoi,
   input logic               irq_out,
   input logic               ack_valid,
   input logic [VEC_W-1:0]   ppr_out,
   input logic [CNT_W-1:0]   event_count,
   input logic [VEC_W-1:0]   tpr_q,
   input logic [VEC_W:0]     svr_q,
   input logic [NUM_VEC-1:0] irr_q,
   input logic [NUM_VEC-1:0] isr_q
);
   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (svr_q[VEC_W] && irr_q != '0));

   assert_ppr_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_out[VEC_W-1 -: CLS_W] >= tpr_q[VEC_W-1 -: CLS_W]);

   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> ack_valid);

   assert_ack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !ack_valid);

   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (event_count == $past(event_count)) ||
               (event_count == CNT_W'($past(event_count) + 1'b1)));

   assert_count_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(event_count));

   assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && isr_q == '0) |=> (isr_q == '0));

   assert_spur_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !svr_q[VEC_W] && !req_valid && !eoi) |=> ($stable(irr_q) && $stable(isr_q)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_VEC (NUM_VEC),
   .CLS_W   (CLS_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .ack         (ack),
   .eoi         (eoi),
   .irq_out     (irq_out),
   .ack_valid   (ack_valid),
   .ppr_out     (ppr_out),
   .event_count (event_count),
   .tpr_q       (tpr_q),
   .svr_q       (svr_q),
   .irr_q       (irr_q),
   .isr_q       (isr_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   localparam logic [2:0] OP_REQ = 3'd1;
   localparam logic [2:0] OP_ACK = 3'd2;
   localparam logic [2:0] OP_EOI = 3'd3;
   localparam logic [2:0] OP_TPR = 3'd4;
   localparam logic [2:0] OP_SPR = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [11:0] data;
      logic        lvl;
      logic        chk_ack;
      logic [7:0]  exp_vec;
      logic        exp_lvl;
      logic        exp_irq;
      logic [7:0]  exp_ppr;
   } step_t;

   localparam int NSTEP = 32;
   localparam step_t STEPS [NSTEP] = '{
      '{OP_REQ, 12'h045, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{OP_SPR, 12'h1F0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_REQ, 12'h082, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h82, 1'b1, 1'b0, 8'h80},
      '{OP_REQ, 12'h091, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h80},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h91, 1'b0, 1'b0, 8'h90},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h80},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_TPR, 12'h050, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h50},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0, 8'h50},
      '{OP_TPR, 12'h03C, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3C},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0, 8'h40},
      '{OP_REQ, 12'h040, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h40},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3C},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h40, 1'b1, 1'b0, 8'h40},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3C},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3C},
      '{OP_TPR, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{OP_REQ, 12'h005, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 8'h00},
      '{OP_REQ, 12'h003, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_SPR, 12'h0F0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0, 8'h00},
      '{OP_SPR, 12'h1E7, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 8'h00},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'hE7, 1'b0, 1'b0, 8'h00},
      '{OP_REQ, 12'h060, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_REQ, 12'h060, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},
      '{OP_ACK, 12'h000, 1'b0, 1'b1, 8'h60, 1'b0, 1'b0, 8'h60},
      '{OP_EOI, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_level = 1'b0;
   logic [31:0] wr_data = '0;
   logic        tpr_wr = 1'b0;
   logic        spur_wr = 1'b0;
   logic        ack = 1'b0;
   logic        eoi = 1'b0;
   logic        irq_out, ack_valid, ack_level;
   logic [7:0]  ack_vector, ppr_out;
   logic [15:0] event_count;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_vector (req_vector), .req_level (req_level),
      .wr_data (wr_data), .tpr_wr (tpr_wr), .spur_wr (spur_wr),
      .ack (ack), .eoi (eoi),
      .irq_out (irq_out), .ack_valid (ack_valid), .ack_vector (ack_vector),
      .ack_level (ack_level), .ppr_out (ppr_out), .event_count (event_count)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock with the given strobes; returns just after the edge
   task automatic cycle(input logic rv, input logic [7:0] vec, input logic lvl,
                        input logic a, input logic e, input logic tw,
                        input logic sw, input logic [31:0] d);
      @(negedge clk);
      req_valid = rv; req_vector = vec; req_level = lvl;
      ack = a; eoi = e; tpr_wr = tw; spur_wr = sw; wr_data = d;
      @(posedge clk);
      #1;
      req_valid = 0; ack = 0; eoi = 0; tpr_wr = 0; spur_wr = 0;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 irq_out", 32'(irq_out), 32'd0);
      check("R1 ppr_out", 32'(ppr_out), 32'd0);
      check("R1 event_count", 32'(event_count), 32'd0);
      check("R1 ack_valid", 32'(ack_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R7 R8 (step 1 also covers R1 disabled start)
      for (int i = 0; i < NSTEP; i++) begin
         step_t s;
         s = STEPS[i];
         cycle(s.op == OP_REQ, s.data[7:0], s.lvl, s.op == OP_ACK, s.op == OP_EOI,
               s.op == OP_TPR, s.op == OP_SPR, 32'(s.data));
         check($sformatf("R5 irq step %0d", i), 32'(irq_out), 32'(s.exp_irq));
         check($sformatf("R4/R8 ppr step %0d", i), 32'(ppr_out), 32'(s.exp_ppr));
         if (s.chk_ack) begin
            check($sformatf("R2/R6/R7 ack_vector step %0d", i), 32'(ack_vector), 32'(s.exp_vec));
            check($sformatf("R3 ack_level step %0d", i), 32'(ack_level), 32'(s.exp_lvl));
            check($sformatf("R7 ack_valid step %0d", i), 32'(ack_valid), 32'd1);
         end
      end
      // R9: seven first arrivals, one repeat of 0x60
      check("R9 count after table", 32'(event_count), 32'd7);

      // R9: coalesced arrival of 0x22
      cycle(1, 8'h22, 0, 0, 0, 0, 0, 0);
      check("R9 first arrival", 32'(event_count), 32'd8);
      cycle(1, 8'h22, 0, 0, 0, 0, 0, 0);
      check("R9 repeat arrival", 32'(event_count), 32'd8);
      check("R7 ack_valid idle", 32'(ack_valid), 32'd0);

      // R11: acknowledge and re-request of 0x22 in the same cycle
      cycle(1, 8'h22, 0, 1, 0, 0, 0, 0);
      check("R11 ack_vector", 32'(ack_vector), 32'h22);
      check("R11 count unchanged", 32'(event_count), 32'd8);
      check("R11 ppr from service", 32'(ppr_out), 32'h20);
      check("R11 same class blocked", 32'(irq_out), 32'd0);
      cycle(0, 0, 0, 0, 1, 0, 0, 0);
      check("R11 request survived", 32'(irq_out), 32'd1);
      cycle(0, 0, 0, 1, 0, 0, 0, 0);
      check("R11 second ack", 32'(ack_vector), 32'h22);
      cycle(0, 0, 0, 0, 1, 0, 0, 0);
      check("R8 retire", 32'(ppr_out), 32'd0);

      // R10: spurious write keeps only bits [8:0]
      cycle(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_F3A5);
      cycle(0, 0, 0, 1, 0, 0, 0, 0);
      check("R10 spurious low byte", 32'(ack_vector), 32'hA5);
      cycle(1, 8'h10, 0, 0, 0, 0, 0, 0);
      check("R10 enable bit kept", 32'(irq_out), 32'd1);
      cycle(0, 0, 0, 1, 0, 0, 0, 0);
      check("R10 ack after mask", 32'(ack_vector), 32'h10);
      cycle(0, 0, 0, 0, 1, 0, 0, 0);

      // R10: task priority takes bits [7:0]
      cycle(0, 0, 0, 0, 0, 1, 0, 32'hABCD_E12F);
      check("R10 tpr low byte", 32'(ppr_out), 32'h2F);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule